// File: doc/BRIEF.md
# Line Transceiver Power-State Controller

This block decides when a line transceiver is powered. Power requests arrive from three places: a register command interface driven by a local microcontroller, 4-bit command/indicate codes received in a time-division control channel, and a data pin that serves as a wake strobe when the block is the clock master of that channel. From these requests the block drives the enable for the transceiver circuitry, the enable for the output clocks, the line-signal-detect output and the code it transmits back on the control channel.

There are two ways to power down. A register command drops power at once. A command/indicate request instead enters a draining state. In that state the block answers with the deactivation code for a set number of frames. It then powers down at the end of a channel slot, and only if the activation logic reports that the line is fully deactivated. A soft reset restarts only the activation controller. A full reset, whether from the pin or from a register command, also restores the configuration. A quiet mode masks wake-up tone reporting while the block is unpowered. The activation state matrix, the analog front end and the oscillator lie outside this block. They appear here only as the status inputs `slot_end`, `deact_full` and `tone_det`.

Top module: `pwr_ctl_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the block reads state OFF (`pwr_state`=00), `pwr_on`=0, `clk_en`=0, `lsd_oe`=1, `cfg_q`=default (000) and `ctl_if_en`=0. `act_rst` is 1 while `rst` is high and returns to 0 one edge after release.
- R2: A `cfg_wr` sets `ctl_if_en` to 1. Register commands (`reg_pup`, `reg_pdn`, `reg_res`, `reg_rst`) have no effect while `ctl_if_en` is 0. In register mode (`cfg_q` bit 0 = 0), `reg_pup` moves an unpowered block to ON (01) at the next edge, with `pwr_on`=1.
- R3: In register mode, `reg_pdn` moves an ON or DRAIN_DI block straight to the unpowered state at the next edge. No deactivation code is sent (`di_tx` stays 0), and `clk_en` falls on that same edge.
- R4: `clk_en` is 1 exactly when the block is ON or DRAIN_DI and the clock-master bit (`cfg_q` bit 1) was set at the edge that produced the state.
- R5: In channel mode as a clock slave (bit 0 = 1, bit 1 = 0), a valid received code 0000 powers the block up. `reg_pup` is ignored in channel mode.
- R6: In channel mode as clock master (bits 0 and 1 = 1), `bx_n` sampled low while unpowered powers the block up. A received code 0000 does not wake it.
- R7: In channel mode, a valid received code 1111 while ON moves the block to DRAIN_DI (10). `di_tx` is 1 exactly while the state is DRAIN_DI.
- R8: DRAIN_DI leaves for the unpowered state only on a `slot_end` pulse with `deact_full` high, and no earlier than the second `slot_end` after entry. On every other cycle it stays in DRAIN_DI, unless R3 or R9 applies.
- R9: A valid received code 0000 in DRAIN_DI (channel mode) returns the block to ON.
- R10: While powered, `lsd_oe`=0. In OFF, `lsd_oe`=1 and `lsd_n` (active low) equals the inverse of `tone_det` as sampled at the previous edge.
- R11: When the quiet bit (`cfg_q` bit 2) is set, the unpowered state is QUIET (11). In QUIET, `lsd_oe`=1 and `lsd_n`=1 whatever the value of `tone_det`.
- R12: `reg_res` pulses `act_rst` for one cycle and leaves `pwr_state` and `cfg_q` unchanged, whether the block is powered or not.
- R13: `reg_rst` pulses `act_rst`, restores `cfg_q` to its default, forces state OFF, and keeps `ctl_if_en` at 1.
- R14: Powering up or down leaves `cfg_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration: bit0 channel mode, bit1 clock master, bit2 quiet |
| reg_pup | input | 1 | Register power-up command pulse |
| reg_pdn | input | 1 | Register immediate power-down pulse |
| reg_res | input | 1 | Register activation-controller reset pulse |
| reg_rst | input | 1 | Register full reset pulse |
| ci_valid | input | 1 | Received command/indicate code valid |
| ci_code | input | CI_W | Received command/indicate code |
| bx_n | input | 1 | Channel data input; low requests wake in master mode |
| slot_end | input | 1 | End of the assigned channel slot |
| deact_full | input | 1 | Line fully deactivated |
| tone_det | input | 1 | Wake-up tone detected on the line |
| pwr_state | output | 2 | 00 OFF, 01 ON, 10 DRAIN_DI, 11 QUIET |
| pwr_on | output | 1 | Circuitry enable |
| clk_en | output | 1 | Output clock enable |
| lsd_n | output | 1 | Line-signal-detect value, active low |
| lsd_oe | output | 1 | Line-signal-detect drive enable |
| di_tx | output | 1 | Transmit deactivation code 1111 this frame |
| act_rst | output | 1 | Activation controller reset pulse |
| cfg_q | output | 3 | Current configuration |
| ctl_if_en | output | 1 | Register command interface enabled |

## Verification
The assertions assume that every request input is a single-cycle pulse. They also assume that a configuration write never coincides with a full reset or a soft reset, and that `bx_n` rests high except when the bench deliberately asks for a wake. The stimulus drives each request for exactly one clock and then clears it. Configuration writes are issued on cycles of their own, and `bx_n` is pulled low only during the master-mode wake sequence. The drain checks control `slot_end` and `deact_full` separately, so the early-exit and late-exit cases of R8 each fall on a known edge.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_DRAIN = 2'd2,
    PS_QUIET = 2'd3
  } pstate_t;

  // bit0 channel mode, bit1 clock master, bit2 quiet
  typedef struct packed {
    logic quiet;
    logic master;
    logic chan;
  } pcfg_t;

  localparam int unsigned PCFG_W = $bits(pcfg_t);

  function automatic logic is_powered(pstate_t s);
    return (s == PS_ON) || (s == PS_DRAIN);
  endfunction

endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import pwr_ctl_pkg::*;
#(
  parameter logic [PCFG_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_rst,
  input  logic              wr,
  input  logic [PCFG_W-1:0] wdata,
  output pcfg_t             cfg,
  output logic              if_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= pcfg_t'(RST_VAL);
      if_en <= 1'b0;
    end else if (full_rst) begin
      // software full reset keeps the command interface alive
      cfg   <= pcfg_t'(RST_VAL);
    end else if (wr) begin
      cfg   <= pcfg_t'(wdata);
      if_en <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_req_decode.sv
module pwr_req_decode #(
  parameter int unsigned CI_W = 4
) (
  input  logic            chan,
  input  logic            master,
  input  logic            if_en,
  input  logic            reg_pup,
  input  logic            reg_pdn,
  input  logic            reg_res,
  input  logic            reg_rst,
  input  logic            ci_valid,
  input  logic [CI_W-1:0] ci_code,
  input  logic            bx_n,
  output logic            wake,
  output logic            abort,
  output logic            pdn_now,
  output logic            pdn_defer,
  output logic            soft_res,
  output logic            full_rst
);

  localparam logic [CI_W-1:0] CODE_UP = '0;
  localparam logic [CI_W-1:0] CODE_DI = '1;

  logic ci_up, ci_di;

  always_comb begin
    ci_up     = ci_valid && (ci_code == CODE_UP);
    ci_di     = ci_valid && (ci_code == CODE_DI);
    wake      = chan ? (master ? !bx_n : ci_up) : (if_en && reg_pup);
    abort     = chan && ci_up;
    pdn_now   = !chan && if_en && reg_pdn;
    pdn_defer = chan && ci_di;
    soft_res  = if_en && reg_res;
    full_rst  = if_en && reg_rst;
  end

endmodule

// File: rtl/pwr_drain_cnt.sv
module pwr_drain_cnt #(
  parameter int unsigned DI_REPEAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic done
);

  generate
    if (DI_REPEAT <= 1) begin : g_single
      assign done = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DI_REPEAT);
      localparam logic [CW-1:0] LAST = CW'(DI_REPEAT - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt <= '0;
        end else if (tick && (cnt != LAST)) begin
          cnt <= cnt + 1'b1;
        end
      end

      assign done = (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    quiet,
  input  logic    master,
  input  logic    wake,
  input  logic    abort,
  input  logic    pdn_now,
  input  logic    pdn_defer,
  input  logic    soft_res,
  input  logic    full_rst,
  input  logic    slot_end,
  input  logic    deact_full,
  input  logic    tone_det,
  input  logic    drain_done,
  output pstate_t st,
  output logic    enter_drain,
  output logic    pwr_on,
  output logic    clk_en,
  output logic    lsd_n,
  output logic    lsd_oe,
  output logic    di_tx,
  output logic    act_rst
);

  pstate_t nxt, off_st;
  logic    nxt_pwr;

  always_comb begin
    off_st = quiet ? PS_QUIET : PS_OFF;
    nxt    = st;
    unique case (st)
      PS_OFF, PS_QUIET: nxt = wake ? PS_ON : off_st;
      PS_ON: begin
        if (pdn_now)        nxt = off_st;
        else if (pdn_defer) nxt = PS_DRAIN;
      end
      PS_DRAIN: begin
        if (pdn_now)                                  nxt = off_st;
        else if (abort)                               nxt = PS_ON;
        else if (slot_end && drain_done && deact_full) nxt = off_st;
      end
    endcase
    if (full_rst) nxt = PS_OFF;
    nxt_pwr     = is_powered(nxt);
    enter_drain = (nxt == PS_DRAIN) && (st != PS_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_OFF;
      pwr_on  <= 1'b0;
      clk_en  <= 1'b0;
      lsd_n   <= 1'b1;
      lsd_oe  <= 1'b1;
      di_tx   <= 1'b0;
      act_rst <= 1'b1;
    end else begin
      st      <= nxt;
      pwr_on  <= nxt_pwr;
      clk_en  <= nxt_pwr && master;
      lsd_oe  <= !nxt_pwr;
      lsd_n   <= (nxt == PS_OFF) ? !tone_det : 1'b1;
      di_tx   <= (nxt == PS_DRAIN);
      act_rst <= soft_res || full_rst;
    end
  end

endmodule

// File: rtl/pwr_ctl_top.sv
module pwr_ctl_top
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned       CI_W      = 4,
  parameter int unsigned       DI_REPEAT = 2,
  parameter logic [PCFG_W-1:0] CFG_RST   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [PCFG_W-1:0] cfg_wdata,
  input  logic              reg_pup,
  input  logic              reg_pdn,
  input  logic              reg_res,
  input  logic              reg_rst,
  input  logic              ci_valid,
  input  logic [CI_W-1:0]   ci_code,
  input  logic              bx_n,
  input  logic              slot_end,
  input  logic              deact_full,
  input  logic              tone_det,
  output logic [1:0]        pwr_state,
  output logic              pwr_on,
  output logic              clk_en,
  output logic              lsd_n,
  output logic              lsd_oe,
  output logic              di_tx,
  output logic              act_rst,
  output logic [PCFG_W-1:0] cfg_q,
  output logic              ctl_if_en
);

  pcfg_t   cfg;
  pstate_t st;
  logic wake, abort, pdn_now, pdn_defer, soft_res, full_rst;
  logic enter_drain, drain_done;

  pwr_cfg_reg #(.RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst(rst), .full_rst(full_rst), .wr(cfg_wr),
    .wdata(cfg_wdata), .cfg(cfg), .if_en(ctl_if_en)
  );

  pwr_req_decode #(.CI_W(CI_W)) u_dec (
    .chan(cfg.chan), .master(cfg.master), .if_en(ctl_if_en),
    .reg_pup(reg_pup), .reg_pdn(reg_pdn), .reg_res(reg_res), .reg_rst(reg_rst),
    .ci_valid(ci_valid), .ci_code(ci_code), .bx_n(bx_n),
    .wake(wake), .abort(abort), .pdn_now(pdn_now), .pdn_defer(pdn_defer),
    .soft_res(soft_res), .full_rst(full_rst)
  );

  pwr_drain_cnt #(.DI_REPEAT(DI_REPEAT)) u_cnt (
    .clk(clk), .rst(rst), .clr(enter_drain || full_rst),
    .tick(slot_end && (st == PS_DRAIN)), .done(drain_done)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .quiet(cfg.quiet), .master(cfg.master),
    .wake(wake), .abort(abort), .pdn_now(pdn_now), .pdn_defer(pdn_defer),
    .soft_res(soft_res), .full_rst(full_rst), .slot_end(slot_end),
    .deact_full(deact_full), .tone_det(tone_det), .drain_done(drain_done),
    .st(st), .enter_drain(enter_drain), .pwr_on(pwr_on), .clk_en(clk_en),
    .lsd_n(lsd_n), .lsd_oe(lsd_oe), .di_tx(di_tx), .act_rst(act_rst)
  );

  assign pwr_state = st;
  assign cfg_q     = cfg;

endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_if_en,
  input logic       reg_pdn,
  input logic       reg_res,
  input logic       reg_rst,
  input logic       cfg_wr,
  input logic       slot_end,
  input logic [2:0] cfg_q,
  input logic [1:0] pwr_state,
  input logic       pwr_on,
  input logic       clk_en,
  input logic       lsd_n,
  input logic       lsd_oe,
  input logic       di_tx,
  input logic       act_rst
);

  // R3
  reg_pdn_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_if_en && reg_pdn && !cfg_q[0] && pwr_on) |=> (!pwr_on && !di_tx && !clk_en));

  // R4
  clk_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> pwr_on);

  // R7
  di_matches_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) == di_tx);

  // R8
  drain_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2 && !slot_end && !(ctl_if_en && (reg_pdn || reg_rst)))
      |=> (pwr_state == 2'd2 || pwr_state == 2'd1));

  // R10
  lsd_released_on_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd1) |-> !lsd_oe);

  // R11
  quiet_lsd_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3) |-> (lsd_oe && lsd_n));

  // R12
  soft_res_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_if_en && reg_res && !reg_rst && !cfg_wr) |=> (act_rst && $stable(cfg_q)));

  // R13
  full_rst_keeps_if_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_if_en && reg_rst) |=> (ctl_if_en && act_rst && pwr_state == 2'd0));

endmodule

bind pwr_ctl_top pwr_ctl_chk u_chk (
  .clk(clk), .rst(rst), .ctl_if_en(ctl_if_en), .reg_pdn(reg_pdn),
  .reg_res(reg_res), .reg_rst(reg_rst), .cfg_wr(cfg_wr), .slot_end(slot_end),
  .cfg_q(cfg_q), .pwr_state(pwr_state), .pwr_on(pwr_on), .clk_en(clk_en),
  .lsd_n(lsd_n), .lsd_oe(lsd_oe), .di_tx(di_tx), .act_rst(act_rst)
);

// File: tb/sim_pwr_ctl_top.sv
module sim_pwr_ctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int DI_REP     = 2;
  localparam logic [2:0] CFG_DEF = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, reg_pup = 0, reg_pdn = 0, reg_res = 0, reg_rst = 0;
  logic [2:0] cfg_wdata = '0;
  logic ci_valid = 0;
  logic [3:0] ci_code = '0;
  logic bx_n = 1, slot_end = 0, deact_full = 0, tone_det = 0;

  logic [1:0] pwr_state;
  logic pwr_on, clk_en, lsd_n, lsd_oe, di_tx, act_rst, ctl_if_en;
  logic [2:0] cfg_q;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit model_live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_ctl_top u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .reg_pup(reg_pup), .reg_pdn(reg_pdn), .reg_res(reg_res), .reg_rst(reg_rst),
    .ci_valid(ci_valid), .ci_code(ci_code), .bx_n(bx_n), .slot_end(slot_end),
    .deact_full(deact_full), .tone_det(tone_det), .pwr_state(pwr_state),
    .pwr_on(pwr_on), .clk_en(clk_en), .lsd_n(lsd_n), .lsd_oe(lsd_oe),
    .di_tx(di_tx), .act_rst(act_rst), .cfg_q(cfg_q), .ctl_if_en(ctl_if_en)
  );

  // behavioural reference, states as integers 0 off,1 on,2 drain,3 quiet
  int m_st, m_cnt, nx, offs;
  logic [2:0] m_cfg, oc;
  logic m_en, m_pwr, m_clk, m_lsdn, m_oe, m_di, m_act, wk, full;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cfg = CFG_DEF; m_en = 0; m_cnt = 0;
      m_pwr = 0; m_clk = 0; m_lsdn = 1; m_oe = 1; m_di = 0; m_act = 1;
      model_live = 1;
    end else begin
      oc = m_cfg;
      offs = oc[2] ? 3 : 0;
      nx = m_st;
      full = m_en && reg_rst;
      if (full) begin
        nx = 0; m_cfg = CFG_DEF; m_cnt = 0;
      end else begin
        if (m_st == 0 || m_st == 3) begin
          if (!oc[0]) wk = m_en && reg_pup;
          else if (oc[1]) wk = !bx_n;
          else wk = ci_valid && ci_code == 4'd0;
          nx = wk ? 1 : offs;
        end else if (m_st == 1) begin
          if (!oc[0] && m_en && reg_pdn) nx = offs;
          else if (oc[0] && ci_valid && ci_code == 4'hF) begin nx = 2; m_cnt = 0; end
        end else begin
          if (!oc[0] && m_en && reg_pdn) nx = offs;
          else if (oc[0] && ci_valid && ci_code == 4'd0) nx = 1;
          else if (slot_end) begin
            if (m_cnt >= DI_REP - 1 && deact_full) nx = offs;
            else if (m_cnt < DI_REP - 1) m_cnt = m_cnt + 1;
          end
        end
        if (cfg_wr) m_cfg = cfg_wdata;
      end
      m_act = m_en && (reg_res || reg_rst);
      if (cfg_wr) m_en = 1;
      m_pwr = (nx == 1 || nx == 2);
      m_clk = m_pwr && oc[1];
      m_oe = !m_pwr;
      m_lsdn = (nx == 0) ? !tone_det : 1'b1;
      m_di = (nx == 2);
      m_st = nx;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_model();
    int a, e;
    if (!model_live) return;
    a = {pwr_state, pwr_on, clk_en, lsd_n, lsd_oe, di_tx, act_rst, cfg_q, ctl_if_en};
    e = {m_st[1:0], m_pwr, m_clk, m_lsdn, m_oe, m_di, m_act, m_cfg, m_en};
    chk(cur_req, "model", a, e);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic clr_in();
    cfg_wr = 0; reg_pup = 0; reg_pdn = 0; reg_res = 0; reg_rst = 0;
    ci_valid = 0; ci_code = 0; slot_end = 0;
  endtask

  task automatic wcfg(logic [2:0] v);
    cfg_wr = 1; cfg_wdata = v; cyc(); clr_in();
  endtask

  task automatic ci(logic [3:0] c);
    ci_valid = 1; ci_code = c; cyc(); clr_in();
  endtask

  task automatic slot();
    slot_end = 1; cyc(); clr_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset values
    cur_req = "R1";
    repeat (3) @(negedge clk);
    cmp_model();
    chk("R1", "act_rst in reset", act_rst, 1);
    chk("R1", "lsd_oe in reset", lsd_oe, 1);
    rst = 0;
    cyc();
    chk("R1", "state", pwr_state, 0);
    chk("R1", "pwr_on", pwr_on, 0);
    chk("R1", "act_rst", act_rst, 0);
    chk("R1", "cfg", cfg_q, 0);
    chk("R1", "if_en", ctl_if_en, 0);

    // R2 gating and register power-up
    cur_req = "R2";
    reg_pup = 1; cyc(); clr_in();
    chk("R2", "pup ignored w/o if", pwr_state, 0);
    wcfg(3'b010);
    chk("R2", "if_en after write", ctl_if_en, 1);
    reg_pup = 1; cyc(); clr_in();
    chk("R2", "state on", pwr_state, 1);
    chk("R2", "pwr_on", pwr_on, 1);
    chk("R4", "clk_en master on", clk_en, 1);

    // R3 immediate power-down, R14 cfg kept
    cur_req = "R3";
    reg_pdn = 1; cyc(); clr_in();
    chk("R3", "state off", pwr_state, 0);
    chk("R3", "clk_en off", clk_en, 0);
    chk("R3", "no di", di_tx, 0);
    chk("R14", "cfg kept", cfg_q, 3'b010);

    // R4 slave: no clocks
    cur_req = "R4";
    wcfg(3'b000);
    reg_pup = 1; cyc(); clr_in();
    chk("R4", "pwr_on", pwr_on, 1);
    chk("R4", "clk_en slave", clk_en, 0);
    reg_pdn = 1; cyc(); clr_in();

    // R10 line-signal-detect
    cur_req = "R10";
    tone_det = 1; cyc();
    chk("R10", "lsd_n tone off", lsd_n, 0);
    chk("R10", "lsd_oe off", lsd_oe, 1);
    reg_pup = 1; cyc(); clr_in();
    chk("R10", "lsd_oe on", lsd_oe, 0);
    reg_pdn = 1; cyc(); clr_in();
    chk("R10", "lsd_n tone again", lsd_n, 0);
    tone_det = 0; cyc();
    chk("R10", "lsd_n no tone", lsd_n, 1);

    // R11 quiet
    cur_req = "R11";
    wcfg(3'b100);
    cyc();
    chk("R11", "state quiet", pwr_state, 3);
    tone_det = 1; cyc(); cyc();
    chk("R11", "lsd_n high", lsd_n, 1);
    chk("R11", "lsd_oe", lsd_oe, 1);
    tone_det = 0;

    // R5 channel slave
    cur_req = "R5";
    wcfg(3'b001);
    cyc();
    chk("R5", "back to off", pwr_state, 0);
    reg_pup = 1; cyc(); clr_in();
    chk("R5", "reg_pup ignored", pwr_state, 0);
    ci(4'h0);
    chk("R5", "ci pup", pwr_state, 1);

    // R7 deferred entry
    cur_req = "R7";
    ci(4'hF);
    chk("R7", "state drain", pwr_state, 2);
    chk("R7", "di_tx", di_tx, 1);

    // R8 drain exit conditions
    cur_req = "R8";
    deact_full = 0;
    slot();
    chk("R8", "first slot", pwr_state, 2);
    slot();
    chk("R8", "not deactivated", pwr_state, 2);
    deact_full = 1; cyc();
    chk("R8", "no slot", pwr_state, 2);
    slot();
    chk("R8", "exit", pwr_state, 0);
    chk("R8", "di cleared", di_tx, 0);
    ci(4'h0);
    ci(4'hF);
    slot();
    chk("R8", "only one emission", pwr_state, 2);
    slot();
    chk("R8", "second emission exit", pwr_state, 0);
    deact_full = 0;

    // R9 abort
    cur_req = "R9";
    ci(4'h0);
    ci(4'hF);
    ci(4'h0);
    chk("R9", "abort to on", pwr_state, 1);
    chk("R9", "di off", di_tx, 0);

    // R6 master wake via bx_n
    cur_req = "R6";
    ci(4'hF);
    deact_full = 1; slot(); slot(); deact_full = 0;
    wcfg(3'b011);
    ci(4'h0);
    chk("R6", "ci ignored in master", pwr_state, 0);
    bx_n = 0; cyc(); bx_n = 1;
    chk("R6", "bx wake", pwr_state, 1);
    chk("R6", "clk_en", clk_en, 1);

    // R12 soft reset
    cur_req = "R12";
    reg_res = 1; cyc(); clr_in();
    chk("R12", "act pulse", act_rst, 1);
    chk("R12", "state kept", pwr_state, 1);
    chk("R12", "cfg kept", cfg_q, 3'b011);
    cyc();
    chk("R12", "act single", act_rst, 0);
    ci(4'hF);
    deact_full = 1; slot(); slot(); deact_full = 0;
    reg_res = 1; cyc(); clr_in();
    chk("R12", "act pulse off", act_rst, 1);
    chk("R12", "state off kept", pwr_state, 0);

    // R13 full reset by register
    cur_req = "R13";
    bx_n = 0; cyc(); bx_n = 1;
    reg_rst = 1; cyc(); clr_in();
    chk("R13", "state", pwr_state, 0);
    chk("R13", "cfg default", cfg_q, CFG_DEF);
    chk("R13", "if_en kept", ctl_if_en, 1);
    chk("R13", "act pulse", act_rst, 1);
    chk("R13", "pwr_on", pwr_on, 0);
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule